// File: doc/BRIEF.md
# Flash Status Register Protection Unit

This block sits beside the command decoder of a serial flash memory controller and decides whether each array-modify or status-write command may run. It holds a write-enable latch, a status-write lock bit and a block-protect field. The decoder presents one command strobe per cycle, along with a target address and the new status bits for a status write. One cycle later the unit answers with a single-cycle accept or reject pulse and has already updated its register bits.

The block-protect field selects a protected region that grows downward from the top of the array. The status-write lock bit, together with the live level of an active-low write-protect pin, forms a hardware lock. While that lock holds, the lock bit and the block-protect field cannot change. The lock depends only on the present bit and pin levels, so it does not matter which of the two became active first. The lock is also reported as a level output, and it ends only when the pin returns high.

Top module: `flash_guard_top`

## Requirements
- R1: After reset, the latch, the lock bit and the protect field are all 0, and neither decision pulse is asserted.
- R2: A write-enable strobe sets the latch and a write-disable strobe clears it. Each takes effect at the next clock edge.
- R3: With the lock bit at 0, a status write is accepted exactly when the latch is set, whatever the pin level. An accepted write loads the lock bit and the protect field from the command data.
- R4: With the lock bit at 1 and the pin high, a status write is accepted exactly when the latch is set.
- R5: With the lock bit at 1 and the pin low, a status write is rejected even when the latch is set, and the lock bit and the protect field keep their values.
- R6: `hwLockActive` is high exactly when the lock bit is 1 and the pin is low. This holds whether the bit was written before or after the pin fell.
- R7: Once the hardware lock is active, it lasts until the pin goes high. After that, a latched status write is accepted again.
- R8: For a protect value n from 1 to 2^BP_W−1, the protected region is every address at or above 2^ADDR_W − 2^(ADDR_W−(2^BP_W−1)+n); a value of 0 protects nothing. A program or sector erase that targets the region is rejected. One outside the region with the latch set is accepted.
- R9: A bulk erase is rejected whenever the protect field is nonzero. With the field at 0 and the latch set, it is accepted.
- R10: Every status write, program, sector erase or bulk erase clears the latch, whether it is accepted or rejected.
- R11: Any modify command issued while the latch is clear is rejected.
- R12: The accept or reject pulse appears in the cycle after the strobe and lasts exactly one cycle. The two pulses are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdWren | input | 1 | Write-enable command strobe |
| cmdWrdi | input | 1 | Write-disable command strobe |
| cmdWrsr | input | 1 | Status write command strobe |
| cmdPp | input | 1 | Page program command strobe |
| cmdSe | input | 1 | Sector erase command strobe |
| cmdBe | input | 1 | Bulk erase command strobe |
| cmdAddr | input | ADDR_W | Target byte address for program and sector erase |
| wrsrLock | input | 1 | New lock bit carried by a status write |
| wrsrProt | input | BP_W | New protect field carried by a status write |
| wpPinN | input | 1 | Write-protect pin, active low |
| cmdAccept | output | 1 | Pulse: the modify command was accepted |
| cmdReject | output | 1 | Pulse: the modify command was refused |
| welOut | output | 1 | Write-enable latch |
| lockBitOut | output | 1 | Status-write lock bit |
| protOut | output | BP_W | Block-protect field |
| hwLockActive | output | 1 | Hardware lock in force |

## Verification
The bench builds the unit with ADDR_W = 10 and BP_W = 3. This keeps every region boundary within a short range of addresses: the smallest region starts at 1008, a value of 3 starts at 960, and 7 covers the whole array. As a result, both the first protected address and the last unprotected address can be probed at several protect values. Both orders of entering the hardware lock are driven, and the lock is released through the pin, using the same narrow field width.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

  // Decoded command after priority resolution
  typedef enum logic [2:0] {
    OP_NONE,
    OP_WREN,
    OP_WRDI,
    OP_WRSR,
    OP_PP,
    OP_SE,
    OP_BE
  } opKind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic loadSr;
    logic accept;
    logic reject;
  } ctrlStrobe_t;

endpackage

// File: rtl/flash_guard_ctrl.sv
module flash_guard_ctrl
  import flash_guard_pkg::*;
(
  input  logic        cmdWren,
  input  logic        cmdWrdi,
  input  logic        cmdWrsr,
  input  logic        cmdPp,
  input  logic        cmdSe,
  input  logic        cmdBe,
  input  logic        welQ,
  input  logic        lockBitQ,
  input  logic        wpPinN,
  input  logic        addrProtected,
  input  logic        protNonZero,
  output ctrlStrobe_t strb,
  output logic        hwLock
);

  opKind_e op;
  logic    pass;

  assign hwLock = lockBitQ & ~wpPinN;

  // One command per cycle; modify commands win over latch commands
  always_comb begin
    op = OP_NONE;
    if (cmdWrsr)      op = OP_WRSR;
    else if (cmdPp)   op = OP_PP;
    else if (cmdSe)   op = OP_SE;
    else if (cmdBe)   op = OP_BE;
    else if (cmdWrdi) op = OP_WRDI;
    else if (cmdWren) op = OP_WREN;
  end

  always_comb begin
    strb = '0;
    pass = 1'b0;
    case (op)
      OP_WREN: strb.setWel = 1'b1;
      OP_WRDI: strb.clrWel = 1'b1;
      OP_WRSR: begin
        pass        = welQ & ~hwLock;
        strb.clrWel = 1'b1;
        strb.loadSr = pass;
        strb.accept = pass;
        strb.reject = ~pass;
      end
      OP_PP, OP_SE: begin
        pass        = welQ & ~addrProtected;
        strb.clrWel = 1'b1;
        strb.accept = pass;
        strb.reject = ~pass;
      end
      OP_BE: begin
        pass        = welQ & ~protNonZero;
        strb.clrWel = 1'b1;
        strb.accept = pass;
        strb.reject = ~pass;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/flash_guard_dp.sv
module flash_guard_dp
  import flash_guard_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int BP_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              wrsrLock,
  input  logic [BP_W-1:0]   wrsrProt,
  output logic              welQ,
  output logic              lockBitQ,
  output logic [BP_W-1:0]   protQ,
  output logic              acceptQ,
  output logic              rejectQ,
  output logic              addrProtected,
  output logic              protNonZero
);

  localparam int LEVELS = (1 << BP_W) - 1;
  localparam int CMP_W  = ADDR_W + 1;

  // Lower bound of the protected region for each protect value
  logic [CMP_W-1:0] regionBase [0:LEVELS];

  for (genvar lvl = 0; lvl <= LEVELS; lvl++) begin : g_base
    if (lvl == 0) begin : g_none
      assign regionBase[lvl] = CMP_W'(1) << ADDR_W;
    end else begin : g_lvl
      assign regionBase[lvl] = (CMP_W'(1) << ADDR_W)
                             - (CMP_W'(1) << (ADDR_W - LEVELS + lvl));
    end
  end

  assign protNonZero   = |protQ;
  assign addrProtected = protNonZero && ({1'b0, cmdAddr} >= regionBase[protQ]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      welQ     <= 1'b0;
      lockBitQ <= 1'b0;
      protQ    <= '0;
      acceptQ  <= 1'b0;
      rejectQ  <= 1'b0;
    end else begin
      acceptQ <= strb.accept;
      rejectQ <= strb.reject;
      if (strb.setWel)      welQ <= 1'b1;
      else if (strb.clrWel) welQ <= 1'b0;
      if (strb.loadSr) begin
        lockBitQ <= wrsrLock;
        protQ    <= wrsrProt;
      end
    end
  end

endmodule

// File: rtl/flash_guard_top.sv
module flash_guard_top
  import flash_guard_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int BP_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWren,
  input  logic              cmdWrdi,
  input  logic              cmdWrsr,
  input  logic              cmdPp,
  input  logic              cmdSe,
  input  logic              cmdBe,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              wrsrLock,
  input  logic [BP_W-1:0]   wrsrProt,
  input  logic              wpPinN,
  output logic              cmdAccept,
  output logic              cmdReject,
  output logic              welOut,
  output logic              lockBitOut,
  output logic [BP_W-1:0]   protOut,
  output logic              hwLockActive
);

  ctrlStrobe_t strb;
  logic        welQ;
  logic        lockBitQ;
  logic        addrProtected;
  logic        protNonZero;

  flash_guard_ctrl u_ctrl (
    .cmdWren       (cmdWren),
    .cmdWrdi       (cmdWrdi),
    .cmdWrsr       (cmdWrsr),
    .cmdPp         (cmdPp),
    .cmdSe         (cmdSe),
    .cmdBe         (cmdBe),
    .welQ          (welQ),
    .lockBitQ      (lockBitQ),
    .wpPinN        (wpPinN),
    .addrProtected (addrProtected),
    .protNonZero   (protNonZero),
    .strb          (strb),
    .hwLock        (hwLockActive)
  );

  flash_guard_dp #(
    .ADDR_W (ADDR_W),
    .BP_W   (BP_W)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .cmdAddr       (cmdAddr),
    .wrsrLock      (wrsrLock),
    .wrsrProt      (wrsrProt),
    .welQ          (welQ),
    .lockBitQ      (lockBitQ),
    .protQ         (protOut),
    .acceptQ       (cmdAccept),
    .rejectQ       (cmdReject),
    .addrProtected (addrProtected),
    .protNonZero   (protNonZero)
  );

  assign welOut     = welQ;
  assign lockBitOut = lockBitQ;

endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk #(
  parameter int BP_W = 3
) (
  input logic            clk,
  input logic            rstN,
  input logic            cmdWren,
  input logic            cmdWrdi,
  input logic            cmdWrsr,
  input logic            cmdPp,
  input logic            cmdSe,
  input logic            cmdBe,
  input logic            cmdAccept,
  input logic            cmdReject,
  input logic            welOut,
  input logic            lockBitOut,
  input logic [BP_W-1:0] protOut,
  input logic            hwLockActive
);

  logic anyModify;
  assign anyModify = cmdWrsr | cmdPp | cmdSe | cmdBe;

  assert_pulse_excl_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdAccept && cmdReject));

  assert_wren_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWren && !cmdWrdi && !anyModify) |=> welOut);

  assert_lock_rejects_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrsr && hwLockActive) |=> (cmdReject && $stable(lockBitOut) && $stable(protOut)));

  assert_lock_freeze_R7: assert property (@(posedge clk) disable iff (!rstN)
    hwLockActive |=> (lockBitOut && $stable(protOut)));

  assert_wel_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    anyModify |=> !welOut);

  assert_no_wel_reject_R11: assert property (@(posedge clk) disable iff (!rstN)
    (anyModify && !welOut) |=> cmdReject);

  assert_bulk_guard_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdBe && !cmdWrsr && !cmdPp && !cmdSe && (protOut != '0)) |=> cmdReject);

endmodule

bind flash_guard_top flash_guard_chk #(.BP_W(BP_W)) u_chk (.*);

// File: tb/flash_guard_top_tb_top.sv
module flash_guard_top_tb_top;

  localparam int AW = 10;
  localparam int BW = 3;
  localparam int LEVELS = 7;

  localparam int C_WREN = 1;
  localparam int C_WRDI = 2;
  localparam int C_WRSR = 3;
  localparam int C_PP   = 4;
  localparam int C_SE   = 5;
  localparam int C_BE   = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdWren = 0, cmdWrdi = 0, cmdWrsr = 0, cmdPp = 0, cmdSe = 0, cmdBe = 0;
  logic [AW-1:0] cmdAddr = '0;
  logic          wrsrLock = 0;
  logic [BW-1:0] wrsrProt = '0;
  logic          wpPinN = 1'b1;
  logic          cmdAccept, cmdReject, welOut, lockBitOut, hwLockActive;
  logic [BW-1:0] protOut;

  int nChecks = 0;
  int nFails  = 0;
  bit doneFlag = 0;

  always #10 clk = ~clk;

  flash_guard_top #(.ADDR_W(AW), .BP_W(BW)) dut_i (
    .clk(clk), .rstN(rstN),
    .cmdWren(cmdWren), .cmdWrdi(cmdWrdi), .cmdWrsr(cmdWrsr),
    .cmdPp(cmdPp), .cmdSe(cmdSe), .cmdBe(cmdBe),
    .cmdAddr(cmdAddr), .wrsrLock(wrsrLock), .wrsrProt(wrsrProt),
    .wpPinN(wpPinN),
    .cmdAccept(cmdAccept), .cmdReject(cmdReject), .welOut(welOut),
    .lockBitOut(lockBitOut), .protOut(protOut), .hwLockActive(hwLockActive)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Bench-side model of the protected region
  function automatic bit inRegion(input int addr, input int prot);
    if (prot == 0) return 0;
    return addr >= ((1 << AW) - (1 << (AW - LEVELS + prot)));
  endfunction

  // Drive one strobe for one cycle, then sample at the following negedge
  task automatic issue(input int cmd, input int addr = 0, input bit lk = 0, input int pr = 0);
    @(negedge clk);
    cmdAddr  = AW'(addr);
    wrsrLock = lk;
    wrsrProt = BW'(pr);
    cmdWren  = (cmd == C_WREN);
    cmdWrdi  = (cmd == C_WRDI);
    cmdWrsr  = (cmd == C_WRSR);
    cmdPp    = (cmd == C_PP);
    cmdSe    = (cmd == C_SE);
    cmdBe    = (cmd == C_BE);
    @(negedge clk);
    {cmdWren, cmdWrdi, cmdWrsr, cmdPp, cmdSe, cmdBe} = '0;
  endtask

  task automatic setPin(input bit lvl);
    @(negedge clk);
    wpPinN = lvl;
    #1;
  endtask

  task automatic t_reset();
    check("R1 wel", welOut, 0);
    check("R1 lock", lockBitOut, 0);
    check("R1 prot", protOut, 0);
    check("R1 pulses", {cmdAccept, cmdReject}, 0);
  endtask

  task automatic t_latch();
    issue(C_WREN);
    check("R2 wren sets", welOut, 1);
    issue(C_WRDI);
    check("R2 wrdi clears", welOut, 0);
  endtask

  task automatic t_wrsr_unlocked();
    issue(C_WRSR, 0, 0, 5);
    check("R3 no latch reject", cmdReject, 1);
    check("R3 prot kept", protOut, 0);
    setPin(0);
    issue(C_WREN);
    issue(C_WRSR, 0, 0, 3);
    check("R3 accept pin low", cmdAccept, 1);
    check("R3 prot loaded", protOut, 3);
    check("R10 wel cleared on accept", welOut, 0);
    @(negedge clk);
    check("R12 single pulse", {cmdAccept, cmdReject}, 0);
    setPin(1);
  endtask

  task automatic t_region();
    int exp;
    // protect value 3
    issue(C_WREN); issue(C_PP, 959);
    exp = inRegion(959, 3) ? 0 : 1;
    check("R8 pp below region", cmdAccept, exp);
    issue(C_WREN); issue(C_PP, 960);
    check("R8 pp region start", cmdReject, inRegion(960, 3));
    issue(C_WREN); issue(C_SE, 1023);
    check("R8 se top", cmdReject, 1);
    issue(C_WREN); issue(C_SE, 0);
    check("R8 se bottom", cmdAccept, 1);
    issue(C_WREN); issue(C_BE);
    check("R9 be refused", cmdReject, 1);
    // protect value 1
    issue(C_WREN); issue(C_WRSR, 0, 0, 1);
    issue(C_WREN); issue(C_PP, 1007);
    check("R8 pp below 1008", cmdAccept, !inRegion(1007, 1));
    issue(C_WREN); issue(C_PP, 1008);
    check("R8 pp at 1008", cmdReject, inRegion(1008, 1));
    // protect value 7 covers all
    issue(C_WREN); issue(C_WRSR, 0, 0, 7);
    issue(C_WREN); issue(C_PP, 0);
    check("R8 whole array", cmdReject, 1);
    // protect value 0
    issue(C_WREN); issue(C_WRSR, 0, 0, 0);
    issue(C_WREN); issue(C_BE);
    check("R9 be accepted", cmdAccept, 1);
    issue(C_PP, 5);
    check("R11 no latch reject", cmdReject, 1);
    issue(C_WREN); issue(C_SE, 5);
    issue(C_SE, 5);
    check("R10 wel cleared then reject", cmdReject, 1);
  endtask

  task automatic t_lock_after_bit();
    issue(C_WREN); issue(C_WRSR, 0, 1, 2);
    check("R4 accept pin high", cmdAccept, 1);
    check("R6 no lock pin high", hwLockActive, 0);
    setPin(0);
    check("R6 lock after pin", hwLockActive, 1);
    issue(C_WREN); issue(C_WRSR, 0, 0, 0);
    check("R5 rejected", cmdReject, 1);
    check("R5 lock bit kept", lockBitOut, 1);
    check("R5 prot kept", protOut, 2);
    check("R10 wel cleared on reject", welOut, 0);
    issue(C_WREN); issue(C_PP, 1023);
    check("R8 region under lock", cmdReject, 1);
    setPin(1);
    check("R7 pin high exits", hwLockActive, 0);
    issue(C_WREN); issue(C_WRSR, 0, 1, 5);
    check("R7 write after exit", cmdAccept, 1);
    check("R4 prot loaded", protOut, 5);
    issue(C_WRSR, 0, 0, 0);
    check("R4 no latch reject", cmdReject, 1);
  endtask

  task automatic t_lock_after_pin();
    issue(C_WREN); issue(C_WRSR, 0, 0, 0);
    setPin(0);
    check("R6 pin alone no lock", hwLockActive, 0);
    issue(C_WREN); issue(C_WRSR, 0, 1, 4);
    check("R3 accept lock bit 0", cmdAccept, 1);
    #1;
    check("R6 lock after bit", hwLockActive, 1);
    issue(C_WREN); issue(C_WRSR, 0, 0, 0);
    check("R7 still locked", lockBitOut, 1);
    setPin(1);
    check("R7 released", hwLockActive, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch();
    t_wrsr_unlocked();
    t_region();
    t_lock_after_bit();
    t_lock_after_pin();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!doneFlag) begin
      doneFlag = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule